// File: doc/BRIEF.md
# Indexed Operand Address Generator

This unit turns one indexed-addressing postbyte into a 16-bit effective address. The postbyte picks one of seven forms: a short signed constant offset, auto increment or decrement of a base register (before or after use), an 8-bit offset widened to nine bits, a 16-bit offset, an accumulator offset, a 16-bit-offset memory-indirect form, and an accumulator-D memory-indirect form. The base register is one of X, Y, SP or PC.

The caller pulses `start` with the postbyte and a snapshot of the register file. The unit then pulls any offset bytes through a byte request/valid handshake, most significant byte first. For the indirect forms it reads a 16-bit pointer through a request/valid read port. When the address is ready it pulses `done` for one cycle. The result stays on the outputs until the next `start`. The result carries an optional base-register writeback, an extra-cycle flag and a reject flag. The reject flag is for forms that are not allowed when the `restricted` input is high.

Top module: `idx_ea_gen`

## Requirements
- R1: With postbyte bit 5 = 0, bits 7:6 select the base (0=X, 1=Y, 2=SP, 3=PC). Bits 4:0 are a two's-complement offset added to the base. There is no writeback, no extra cycle and no byte fetch.
- R2: With bit 5 = 1 and bits 7:6 != 11, the form is auto-modify. The base is given by bits 7:6. The step comes from nibble bits 3:0: it is -8..-1 when bit 3 is set (sign-extended), else nibble+1 (+1..+8). `wb_en` is 1, `wb_sel` names the base and `wb_value` = base + step.
- R3: In auto-modify, bit 4 = 0 gives the updated value as the address (pre-modify). Bit 4 = 1 gives the original base (post-modify).
- R4: With bits 7:5 = 111, bits 4:3 select the base. When bit 2 = 0 and bits 2:0 != 011, bit 1 = 1 fetches two offset bytes, high byte first. Bit 1 = 0 fetches one byte, whose high byte is 0xFF when bit 0 = 1 and 0x00 otherwise. The address is base + offset, and `extra_cycle` = 1.
- R5: With bits 7:5 = 111 and bits 2:0 = 011, two offset bytes are fetched. The unit reads the 16-bit word at base + offset, and that word is the address. `extra_cycle` = 1.
- R6: With bits 7:5 = 111 and bit 2 = 1, bits 1:0 give the offset: 00 adds A (zero-extended), 01 adds B, 10 adds D. With 11 the unit reads the word at base + D and uses it as the address, with `extra_cycle` = 1. The other accumulator forms have no extra cycle.
- R7: When PC is the base, its value is `pc_in` (the address after the postbyte) plus the number of offset bytes fetched.
- R8: With `restricted` = 1, the 16-bit-offset-indirect form and the 9/16-bit offset forms are rejected. The result is `ea` = 0 and `reject` = 1, with no byte fetched, no writeback and no extra cycle. Every other form behaves as when `restricted` = 0.
- R9: `done` is a single-cycle pulse. The outputs keep their values until the next `start`.
- R10: After reset, `done`, `opb_req`, `rd_req`, `ea`, `wb_en`, `extra_cycle` and `reject` are 0.
- R11: `rd_req` stays high until `rd_valid` is seen, with a steady address. `opb_req` holds until each byte arrives. The two requests are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin one address computation |
| postbyte | input | 8 | Indexed-mode postbyte |
| restricted | input | 1 | Reject offset and 16-bit-offset-indirect forms |
| x_in | input | 16 | X register |
| y_in | input | 16 | Y register |
| sp_in | input | 16 | Stack pointer |
| pc_in | input | 16 | Program counter after the postbyte |
| a_in | input | 8 | Accumulator A |
| b_in | input | 8 | Accumulator B |
| d_in | input | 16 | Accumulator D |
| opb_req | output | 1 | Request next offset byte |
| opb_valid | input | 1 | Offset byte present |
| opb_data | input | 8 | Offset byte |
| rd_req | output | 1 | Pointer read request |
| rd_addr | output | 16 | Pointer read address |
| rd_valid | input | 1 | Pointer read data present |
| rd_data | input | 16 | Pointer read data |
| done | output | 1 | Result valid pulse |
| ea | output | 16 | Effective address |
| wb_en | output | 1 | Base register writeback required |
| wb_sel | output | 2 | Writeback register (0=X,1=Y,2=SP,3=PC) |
| wb_value | output | 16 | Writeback value |
| extra_cycle | output | 1 | Form costs one extra cycle |
| reject | output | 1 | Form rejected in restricted mode |

## Verification
A wrongly decoded postbyte shows up in the same `done` pulse in one of three ways: a wrong base, offset or form, an extra or missing offset byte on the fetch handshake, or a wrong writeback or extra-cycle flag. A bad byte counter either hangs the unit, which the caller sees as a missing `done`, or pulls one byte too many, which the bench counts. A wrong pointer address shows up as a wrong `ea` after the single read. A corrupted hold register shows up as an `ea` that changes between `done` and the next `start`.

// File: rtl/idx_pkg.sv
package idx_pkg;

    localparam int AW = 16;
    localparam int BW = 8;

    typedef enum logic [2:0] {
        M_CONST5,
        M_AUTO,
        M_OFF9,
        M_OFF16,
        M_IND16,
        M_ACC,
        M_ACCIND
    } mode_e;

    typedef enum logic [1:0] {
        BR_X  = 2'd0,
        BR_Y  = 2'd1,
        BR_SP = 2'd2,
        BR_PC = 2'd3
    } base_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_CALC,
        S_READ,
        S_DONE
    } state_e;

    typedef struct packed {
        mode_e          mode;
        base_e          base;
        logic [AW-1:0]  imm;
        logic           post;
        logic [1:0]     nbytes;
        logic           neg9;
        logic [1:0]     acc;
        logic           extra;
        logic           blocked;
    } dec_t;

    function automatic logic [AW-1:0] sext5(input logic [4:0] v);
        return {{(AW-5){v[4]}}, v};
    endfunction

    function automatic logic [AW-1:0] auto_step(input logic [3:0] nib);
        if (nib[3])
            return {{(AW-4){1'b1}}, nib};
        return AW'(nib) + AW'(1);
    endfunction

    function automatic logic is_indirect(input mode_e m);
        return (m == M_IND16) || (m == M_ACCIND);
    endfunction

endpackage

// File: rtl/idx_decode.sv
module idx_decode
    import idx_pkg::*;
(
    input  logic [BW-1:0] postbyte,
    input  logic          restricted,
    output dec_t          dec
);

    always_comb begin
        dec        = '0;
        dec.mode   = M_CONST5;
        dec.base   = base_e'(postbyte[7:6]);
        if (!postbyte[5]) begin
            dec.mode = M_CONST5;
            dec.imm  = sext5(postbyte[4:0]);
        end else if (postbyte[7:6] != 2'b11) begin
            dec.mode = M_AUTO;
            dec.imm  = auto_step(postbyte[3:0]);
            dec.post = postbyte[4];
        end else begin
            dec.base = base_e'(postbyte[4:3]);
            if (postbyte[2:0] == 3'b011) begin
                dec.mode    = M_IND16;
                dec.nbytes  = 2'd2;
                dec.extra   = 1'b1;
                dec.blocked = restricted;
            end else if (!postbyte[2]) begin
                dec.mode    = postbyte[1] ? M_OFF16 : M_OFF9;
                dec.nbytes  = postbyte[1] ? 2'd2 : 2'd1;
                dec.neg9    = postbyte[0];
                dec.extra   = 1'b1;
                dec.blocked = restricted;
            end else begin
                dec.acc   = postbyte[1:0];
                dec.mode  = (postbyte[1:0] == 2'b11) ? M_ACCIND : M_ACC;
                dec.extra = (postbyte[1:0] == 2'b11);
            end
        end
    end

endmodule

// File: rtl/idx_opnd_fetch.sv
module idx_opnd_fetch
    import idx_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    input  logic [1:0]    nbytes,
    output logic          opb_req,
    input  logic          opb_valid,
    input  logic [BW-1:0] opb_data,
    output logic [AW-1:0] value,
    output logic          fin
);

    logic [1:0] remain_q;

    assign opb_req = (remain_q != 2'd0);

    always_ff @(posedge clk) begin
        if (rst) begin
            remain_q <= '0;
            value    <= '0;
            fin      <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (go) begin
                remain_q <= nbytes;
                value    <= '0;
            end else if (opb_req && opb_valid) begin
                value    <= {value[AW-BW-1:0], opb_data};
                remain_q <= remain_q - 2'd1;
                fin      <= (remain_q == 2'd1);
            end
        end
    end

    // R11: a pending byte request is held until the byte arrives
    a_r11_opb_hold: assert property (@(posedge clk) disable iff (rst)
        (opb_req && !opb_valid) |=> opb_req);

    // R4: a new fetch never starts while one is still running
    a_r4_no_overlap_go: assert property (@(posedge clk) disable iff (rst)
        go |-> !opb_req);

endmodule

// File: rtl/idx_ea_gen.sv
module idx_ea_gen
    import idx_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [7:0]    postbyte,
    input  logic          restricted,
    input  logic [15:0]   x_in,
    input  logic [15:0]   y_in,
    input  logic [15:0]   sp_in,
    input  logic [15:0]   pc_in,
    input  logic [7:0]    a_in,
    input  logic [7:0]    b_in,
    input  logic [15:0]   d_in,
    output logic          opb_req,
    input  logic          opb_valid,
    input  logic [7:0]    opb_data,
    output logic          rd_req,
    output logic [15:0]   rd_addr,
    input  logic          rd_valid,
    input  logic [15:0]   rd_data,
    output logic          done,
    output logic [15:0]   ea,
    output logic          wb_en,
    output logic [1:0]    wb_sel,
    output logic [15:0]   wb_value,
    output logic          extra_cycle,
    output logic          reject
);

    state_e        st_q;
    dec_t          dec_now;
    dec_t          dec_q;
    logic [AW-1:0] x_q, y_q, sp_q, pc_q, d_q;
    logic [BW-1:0] a_q, b_q;
    logic [AW-1:0] ptr_q;
    logic [AW-1:0] fetched;
    logic          fetch_fin;
    logic          fetch_go;
    logic          accept;
    logic [AW-1:0] base_v;
    logic [AW-1:0] off_v;
    logic [AW-1:0] sum_v;

    idx_decode u_dec (
        .postbyte   (postbyte),
        .restricted (restricted),
        .dec        (dec_now)
    );

    assign accept   = (st_q == S_IDLE) && start;
    assign fetch_go = accept && (dec_now.nbytes != 2'd0) && !dec_now.blocked;

    idx_opnd_fetch u_fetch (
        .clk       (clk),
        .rst       (rst),
        .go        (fetch_go),
        .nbytes    (dec_now.nbytes),
        .opb_req   (opb_req),
        .opb_valid (opb_valid),
        .opb_data  (opb_data),
        .value     (fetched),
        .fin       (fetch_fin)
    );

    always_comb begin
        unique case (dec_q.base)
            BR_X:    base_v = x_q;
            BR_Y:    base_v = y_q;
            BR_SP:   base_v = sp_q;
            default: base_v = pc_q + AW'(dec_q.nbytes);
        endcase
    end

    always_comb begin
        unique case (dec_q.mode)
            M_CONST5,
            M_AUTO:  off_v = dec_q.imm;
            M_OFF9:  off_v = {{(AW-BW){dec_q.neg9}}, fetched[BW-1:0]};
            M_OFF16,
            M_IND16: off_v = fetched;
            default: begin
                unique case (dec_q.acc)
                    2'b00:   off_v = AW'(a_q);
                    2'b01:   off_v = AW'(b_q);
                    default: off_v = d_q;
                endcase
            end
        endcase
    end

    assign sum_v   = base_v + off_v;
    assign rd_req  = (st_q == S_READ);
    assign rd_addr = ptr_q;
    assign done    = (st_q == S_DONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= S_IDLE;
            dec_q       <= '0;
            x_q         <= '0;
            y_q         <= '0;
            sp_q        <= '0;
            pc_q        <= '0;
            d_q         <= '0;
            a_q         <= '0;
            b_q         <= '0;
            ptr_q       <= '0;
            ea          <= '0;
            wb_en       <= 1'b0;
            wb_sel      <= '0;
            wb_value    <= '0;
            extra_cycle <= 1'b0;
            reject      <= 1'b0;
        end else begin
            unique case (st_q)
                S_IDLE: begin
                    if (start) begin
                        dec_q <= dec_now;
                        x_q   <= x_in;
                        y_q   <= y_in;
                        sp_q  <= sp_in;
                        pc_q  <= pc_in;
                        d_q   <= d_in;
                        a_q   <= a_in;
                        b_q   <= b_in;
                        st_q  <= fetch_go ? S_FETCH : S_CALC;
                    end
                end
                S_FETCH: begin
                    if (fetch_fin)
                        st_q <= S_CALC;
                end
                S_CALC: begin
                    wb_sel   <= dec_q.base;
                    wb_value <= sum_v;
                    if (dec_q.blocked) begin
                        ea          <= '0;
                        reject      <= 1'b1;
                        wb_en       <= 1'b0;
                        extra_cycle <= 1'b0;
                        st_q        <= S_DONE;
                    end else begin
                        reject      <= 1'b0;
                        wb_en       <= (dec_q.mode == M_AUTO);
                        extra_cycle <= dec_q.extra;
                        if (is_indirect(dec_q.mode)) begin
                            ptr_q <= sum_v;
                            st_q  <= S_READ;
                        end else begin
                            ea   <= (dec_q.mode == M_AUTO && dec_q.post) ? base_v : sum_v;
                            st_q <= S_DONE;
                        end
                    end
                end
                S_READ: begin
                    if (rd_valid) begin
                        ea   <= rd_data;
                        st_q <= S_DONE;
                    end
                end
                default: st_q <= S_IDLE;
            endcase
        end
    end

    // R9: completion is a one-cycle pulse
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9: results stay put from done until the next start
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> $stable(ea) && $stable(reject) && $stable(wb_en));

    // R11: read request held with a steady address until data arrives
    a_r11_rd_hold: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !rd_valid) |=> rd_req && $stable(rd_addr));

    // R11: byte fetch and pointer read never overlap
    a_r11_no_both: assert property (@(posedge clk) disable iff (rst)
        !(opb_req && rd_req));

    // R8: a rejection yields address zero with no side effects
    a_r8_reject_clean: assert property (@(posedge clk) disable iff (rst)
        (done && reject) |-> (ea == '0) && !wb_en && !extra_cycle);

    // R2: writeback only accompanies an auto-modify result
    a_r2_wb_auto_only: assert property (@(posedge clk) disable iff (rst)
        (done && wb_en) |-> !extra_cycle && !reject);

endmodule

// File: tb/idx_ea_gen_tb_top.sv
module idx_ea_gen_tb_top;

    localparam logic [15:0] XV  = 16'h1000;
    localparam logic [15:0] YV  = 16'h2000;
    localparam logic [15:0] SPV = 16'h3000;
    localparam logic [15:0] PCV = 16'h4000;
    localparam logic [7:0]  AV  = 8'h85;
    localparam logic [7:0]  BV  = 8'h12;
    localparam logic [15:0] DV  = 16'h0304;
    localparam logic [15:0] MEMKEY = 16'hA5C3;

    typedef struct packed {
        logic [7:0]  rq;
        logic [7:0]  pb;
        logic        rs;
        logic [15:0] ob;
        logic [1:0]  nb;
        logic [15:0] ea;
        logic        wb;
        logic [1:0]  ws;
        logic [15:0] wv;
        logic        ex;
        logic        rj;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VECS [NV] = '{
        // R1 constant offsets
        '{8'd1, 8'h05, 1'b0, 16'h0000, 2'd0, 16'h1005, 1'b0, 2'd0, 16'h0000, 1'b0, 1'b0},
        '{8'd1, 8'h5F, 1'b0, 16'h0000, 2'd0, 16'h1FFF, 1'b0, 2'd0, 16'h0000, 1'b0, 1'b0},
        '{8'd1, 8'h90, 1'b0, 16'h0000, 2'd0, 16'h2FF0, 1'b0, 2'd0, 16'h0000, 1'b0, 1'b0},
        // R7 constant offset on PC, no bytes
        '{8'd7, 8'hC2, 1'b0, 16'h0000, 2'd0, 16'h4002, 1'b0, 2'd0, 16'h0000, 1'b0, 1'b0},
        // R2 R3 auto-modify pre/post, +1 +8 -1 -8
        '{8'd3, 8'h20, 1'b0, 16'h0000, 2'd0, 16'h1001, 1'b1, 2'd0, 16'h1001, 1'b0, 1'b0},
        '{8'd3, 8'h37, 1'b0, 16'h0000, 2'd0, 16'h1000, 1'b1, 2'd0, 16'h1008, 1'b0, 1'b0},
        '{8'd2, 8'h6F, 1'b0, 16'h0000, 2'd0, 16'h1FFF, 1'b1, 2'd1, 16'h1FFF, 1'b0, 1'b0},
        '{8'd2, 8'hB8, 1'b0, 16'h0000, 2'd0, 16'h3000, 1'b1, 2'd2, 16'h2FF8, 1'b0, 1'b0},
        // R4 nine-bit and sixteen-bit offsets
        '{8'd4, 8'hE0, 1'b0, 16'h007F, 2'd1, 16'h107F, 1'b0, 2'd0, 16'h0000, 1'b1, 1'b0},
        '{8'd4, 8'hE9, 1'b0, 16'h00F0, 2'd1, 16'h1FF0, 1'b0, 2'd0, 16'h0000, 1'b1, 1'b0},
        '{8'd4, 8'hF2, 1'b0, 16'hFF00, 2'd2, 16'h2F00, 1'b0, 2'd0, 16'h0000, 1'b1, 1'b0},
        // R7 PC base advanced by offset bytes
        '{8'd7, 8'hFA, 1'b0, 16'h1234, 2'd2, 16'h5236, 1'b0, 2'd0, 16'h0000, 1'b1, 1'b0},
        '{8'd7, 8'hF8, 1'b0, 16'h0005, 2'd1, 16'h4006, 1'b0, 2'd0, 16'h0000, 1'b1, 1'b0},
        // R5 sixteen-bit offset indirect
        '{8'd5, 8'hE3, 1'b0, 16'h0020, 2'd2, 16'hB5E3, 1'b0, 2'd0, 16'h0000, 1'b1, 1'b0},
        '{8'd5, 8'hFB, 1'b0, 16'h0010, 2'd2, 16'hE5D1, 1'b0, 2'd0, 16'h0000, 1'b1, 1'b0},
        // R6 accumulator offsets and D indirect
        '{8'd6, 8'hE4, 1'b0, 16'h0000, 2'd0, 16'h1085, 1'b0, 2'd0, 16'h0000, 1'b0, 1'b0},
        '{8'd6, 8'hED, 1'b0, 16'h0000, 2'd0, 16'h2012, 1'b0, 2'd0, 16'h0000, 1'b0, 1'b0},
        '{8'd6, 8'hF6, 1'b0, 16'h0000, 2'd0, 16'h3304, 1'b0, 2'd0, 16'h0000, 1'b0, 1'b0},
        '{8'd6, 8'hE7, 1'b0, 16'h0000, 2'd0, 16'hB6C7, 1'b0, 2'd0, 16'h0000, 1'b1, 1'b0},
        // R8 restricted: rejected forms
        '{8'd8, 8'hE3, 1'b1, 16'h0020, 2'd0, 16'h0000, 1'b0, 2'd0, 16'h0000, 1'b0, 1'b1},
        '{8'd8, 8'hE0, 1'b1, 16'h007F, 2'd0, 16'h0000, 1'b0, 2'd0, 16'h0000, 1'b0, 1'b1},
        '{8'd8, 8'hFA, 1'b1, 16'h1234, 2'd0, 16'h0000, 1'b0, 2'd0, 16'h0000, 1'b0, 1'b1},
        // R8 restricted: allowed forms unchanged
        '{8'd8, 8'hE7, 1'b1, 16'h0000, 2'd0, 16'hB6C7, 1'b0, 2'd0, 16'h0000, 1'b1, 1'b0},
        '{8'd8, 8'h37, 1'b1, 16'h0000, 2'd0, 16'h1000, 1'b1, 2'd0, 16'h1008, 1'b0, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [7:0]  postbyte = '0;
    logic        restricted = 1'b0;
    logic        opb_req, opb_valid;
    logic [7:0]  opb_data;
    logic        rd_req, rd_valid;
    logic [15:0] rd_addr, rd_data;
    logic        done, wb_en, extra_cycle, reject;
    logic [15:0] ea, wb_value;
    logic [1:0]  wb_sel;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int taken  = 0;
    int reads  = 0;
    int op_cnt = 0;
    int rd_cnt = 0;
    int op_wait_cfg = 0;
    int rd_wait_cfg = 0;
    logic [15:0] cur_ob = '0;
    logic [1:0]  cur_nb = '0;
    int          base_taken = 0;

    always #2 clk = ~clk;

    idx_ea_gen dut_i (
        .clk(clk), .rst(rst), .start(start), .postbyte(postbyte),
        .restricted(restricted), .x_in(XV), .y_in(YV), .sp_in(SPV),
        .pc_in(PCV), .a_in(AV), .b_in(BV), .d_in(DV),
        .opb_req(opb_req), .opb_valid(opb_valid), .opb_data(opb_data),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
        .done(done), .ea(ea), .wb_en(wb_en), .wb_sel(wb_sel),
        .wb_value(wb_value), .extra_cycle(extra_cycle), .reject(reject)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (opb_req && opb_valid) taken <= taken + 1;
        if (rd_req && rd_valid)   reads <= reads + 1;
    end

    always @(negedge clk) begin
        if (opb_req) begin
            if (op_cnt > 0) begin
                op_cnt    <= op_cnt - 1;
                opb_valid <= 1'b0;
            end else begin
                opb_valid <= 1'b1;
            end
            opb_data <= (cur_nb == 2'd2 && (taken - base_taken) == 0) ? cur_ob[15:8] : cur_ob[7:0];
        end else begin
            opb_valid <= 1'b0;
            op_cnt    <= op_wait_cfg;
            opb_data  <= 8'h00;
        end
        if (rd_req) begin
            if (rd_cnt > 0) begin
                rd_cnt   <= rd_cnt - 1;
                rd_valid <= 1'b0;
            end else begin
                rd_valid <= 1'b1;
            end
            rd_data <= rd_addr ^ MEMKEY;
        end else begin
            rd_valid <= 1'b0;
            rd_cnt   <= rd_wait_cfg;
            rd_data  <= 16'h0000;
        end
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary_and_end();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc > 100000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=<100000", cyc);
            summary_and_end();
        end
    end

    task automatic run_op(input vec_t v, input string tag);
        int n;
        int rd_before;
        string t;
        t = $sformatf("R%0d %s pb=%h", v.rq, tag, v.pb);
        @(negedge clk);
        cur_ob     = v.ob;
        cur_nb     = v.rs ? 2'd0 : v.nb;
        base_taken = taken;
        rd_before  = reads;
        postbyte   = v.pb;
        restricted = v.rs;
        start      = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        while (!done && n < 60) begin
            @(negedge clk);
            n++;
        end
        chk({t, " done"}, {15'd0, done}, 16'd1);
        chk({t, " ea"}, ea, v.ea);
        chk({t, " wb_en"}, {15'd0, wb_en}, {15'd0, v.wb});
        if (v.wb) begin
            chk({t, " wb_sel"}, {14'd0, wb_sel}, {14'd0, v.ws});
            chk({t, " wb_value"}, wb_value, v.wv);
        end
        chk({t, " extra"}, {15'd0, extra_cycle}, {15'd0, v.ex});
        chk({t, " reject"}, {15'd0, reject}, {15'd0, v.rj});
        chk({t, " bytes"}, 16'(taken - base_taken), {14'd0, v.nb});
        chk({t, " reads"}, 16'(reads - rd_before),
            ((v.pb == 8'hE3 || v.pb == 8'hFB || v.pb == 8'hE7) && !v.rj) ? 16'd1 : 16'd0);
        // R9: single pulse and held result
        @(negedge clk);
        chk({t, " R9 pulse"}, {15'd0, done}, 16'd0);
        @(negedge clk);
        chk({t, " R9 hold"}, ea, v.ea);
    endtask

    initial begin
        opb_valid = 1'b0;
        rd_valid  = 1'b0;
        opb_data  = '0;
        rd_data   = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk("R10 done", {15'd0, done}, 16'd0);
        chk("R10 opb_req", {15'd0, opb_req}, 16'd0);
        chk("R10 rd_req", {15'd0, rd_req}, 16'd0);
        chk("R10 ea", ea, 16'd0);
        chk("R10 flags", {13'd0, wb_en, extra_cycle, reject}, 16'd0);

        for (int i = 0; i < NV; i++)
            run_op(VECS[i], "vec");

        // R11 stalled read port and stalled byte port
        rd_wait_cfg = 3;
        op_wait_cfg = 2;
        run_op(VECS[13], "R11 stall");
        run_op(VECS[11], "R11 stall");
        rd_wait_cfg = 0;
        op_wait_cfg = 0;

        // R8 reject followed by a normal form: no leftover reject
        run_op(VECS[20], "R8 seq");
        run_op(VECS[0], "R8 after");

        summary_and_end();
    end

endmodule